// File: doc/BRIEF.md
# Transactional Read/Write Set Tracker

This block keeps the speculative footprint of one hardware transaction in the tag side of a small private data cache. Each direct-mapped block holds a valid bit, a dirty bit, a tag, and two speculative marks. One mark records that the transaction has read the block. The other records that the transaction has written it. The core starts, ends and cancels a transaction with single-cycle control pulses. It also presents its loads and stores on a valid/ready access port. Remote write or invalidate requests arrive as a snoop address and are always taken, with no back-pressure.

Conflicting remote traffic, a needed eviction of a marked block, or an explicit cancel all end the transaction in an abort. On abort the tracker reports which blocks must be dropped, discards every speculatively written block and clears all marks at once. A clean end commits instead: the marks clear in one cycle and the written blocks stay valid and dirty. Stores made inside a transaction stay local until that point.

Dirty data that must leave the cache goes out on a valid/ready writeback port. This happens before a victim is replaced, and before the first speculative store to a block that already holds non-speculative dirty data. The writeback port may be held off indefinitely. While it waits, the access port is not ready.

Top module: `tx_set_tracker`

## Requirements
- R1: A load accepted while a transaction is active marks the block as read. A later snoop to that block's address aborts the transaction. One cycle after the snoop cycle, `abort_o` pulses with `abort_cause_o` = 2 (conflict) and `tx_active_o` drops.
- R2: A store accepted while a transaction is active marks the block as written. A snoop to it aborts with cause 2, and in the same cycle as `abort_o`, `inv_mask_o` has the bit of that block's index set. The index is the low log2(NBLK) address bits; the tag is the rest.
- R3: A transactional store that hits a dirty block not yet marked written first issues a writeback of that block's address. It does not update the block until the writeback handshake. After the handshake the block is marked written.
- R4: On any abort, blocks marked written become invalid. A later access to their index with another tag then causes no writeback. Blocks only marked read keep their valid and dirty state.
- R5: `tx_end_i` during a transaction gives a `commit_o` pulse one cycle later. Blocks written in the transaction stay valid and dirty, so a later eviction writes them back.
- R6: After a commit or an abort all marks are cleared. A snoop in a following transaction to a block touched only in the earlier one does not abort.
- R7: Accesses made with no transaction active set no marks.
- R8: With no transaction active, snoops never abort. `tx_end_i` and `tx_abort_i` are ignored.
- R9: A transactional access that misses on an index whose resident block is marked raises an abort with cause 3 (overflow). The access is dropped.
- R10: Abort wins over commit in the same cycle. When several abort reasons coincide the cause is conflict (2) over overflow (3) over command (1).
- R11: `wb_valid_o` stays high with `wb_addr_o` stable until `wb_ready_i`. `acc_ready_o` is low whenever a writeback is pending.
- R12: An accepted access that misses on an index holding a valid dirty unmarked block writes back `{resident tag, index}` before the new block is installed.
- R13: Out of reset no transaction is active, `acc_ready_o` is high and all pulses are low. `tx_abort_i` during a transaction aborts with cause 1. `tx_begin_i` while a transaction is active is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_begin_i | input | 1 | Start a transaction (pulse) |
| tx_end_i | input | 1 | Request commit (pulse) |
| tx_abort_i | input | 1 | Request abort (pulse) |
| acc_valid_i | input | 1 | Core access present |
| acc_ready_o | output | 1 | Access accepted this cycle if valid |
| acc_write_i | input | 1 | 1 = store, 0 = load |
| acc_addr_i | input | ADDR_W | Block address of the access |
| snp_valid_i | input | 1 | Remote write/invalidate seen |
| snp_addr_i | input | ADDR_W | Block address of the snoop |
| wb_valid_o | output | 1 | Writeback request pending |
| wb_ready_i | input | 1 | Writeback accepted |
| wb_addr_o | output | ADDR_W | Block address to write back |
| abort_o | output | 1 | Transaction aborted (pulse) |
| abort_cause_o | output | 2 | 1 command, 2 conflict, 3 overflow, 0 none |
| inv_mask_o | output | NBLK | Blocks discarded by the abort |
| commit_o | output | 1 | Transaction committed (pulse) |
| tx_active_o | output | 1 | Transaction in progress |

## Verification
A wrong mark shows up only when a snoop or an eviction later touches that block. A mark that is missing or stale appears as an abort missing or extra one cycle after the snoop. A wrong valid or dirty bit appears as a writeback missing or extra in the cycle after the next access to that index. Because of this, the bench follows every mark-setting access with probing snoops or evicting accesses, and compares all outputs against a behavioural model on every clock. This way a corrupted state surfaces within a few cycles of the step that caused it.

// File: rtl/tx_trk_pkg.sv
package tx_trk_pkg;
  typedef enum logic [1:0] {
    CAUSE_NONE     = 2'd0,
    CAUSE_CMD      = 2'd1,
    CAUSE_CONFLICT = 2'd2,
    CAUSE_OVERFLOW = 2'd3
  } abort_cause_e;

  typedef struct packed {
    logic valid;
    logic dirty;
    logic rd;
    logic wr;
  } blk_flags_t;
endpackage

// File: rtl/tx_lookup.sv
module tx_lookup #(
  parameter int ADDR_W = 12,
  parameter int NBLK   = 8,
  localparam int IDX_W = $clog2(NBLK),
  localparam int TAG_W = ADDR_W - IDX_W
) (
  input  logic [ADDR_W-1:0]           addr,
  input  logic [NBLK-1:0]             valid_v,
  input  logic [NBLK-1:0][TAG_W-1:0]  tag_v,
  output logic [IDX_W-1:0]            idx,
  output logic [TAG_W-1:0]            tag,
  output logic                        hit
);
  assign idx = addr[IDX_W-1:0];
  assign tag = addr[ADDR_W-1:IDX_W];
  assign hit = valid_v[idx] && (tag_v[idx] == tag);
endmodule

// File: rtl/tx_tag_store.sv
module tx_tag_store
  import tx_trk_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int NBLK   = 8,
  localparam int IDX_W = $clog2(NBLK),
  localparam int TAG_W = ADDR_W - IDX_W
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       upd_en,
  input  logic [IDX_W-1:0]           upd_idx,
  input  logic [TAG_W-1:0]           upd_tag,
  input  blk_flags_t                 upd_flags,
  input  logic                       clean_en,
  input  logic [IDX_W-1:0]           clean_idx,
  input  logic                       flash_abort,
  input  logic                       flash_commit,
  output logic [NBLK-1:0]            valid_v,
  output logic [NBLK-1:0]            dirty_v,
  output logic [NBLK-1:0]            rd_v,
  output logic [NBLK-1:0]            wr_v,
  output logic [NBLK-1:0][TAG_W-1:0] tag_v
);
  for (genvar i = 0; i < NBLK; i++) begin : g_blk
    blk_flags_t       flags_q, flags_n;
    logic [TAG_W-1:0] tag_q, tag_n;

    always_comb begin
      flags_n = flags_q;
      tag_n   = tag_q;
      if (clean_en && clean_idx == IDX_W'(i)) flags_n.dirty = 1'b0;
      if (upd_en && upd_idx == IDX_W'(i)) begin
        flags_n = upd_flags;
        tag_n   = upd_tag;
      end
      if (flash_abort) begin
        if (flags_n.wr) begin
          flags_n.valid = 1'b0;
          flags_n.dirty = 1'b0;
        end
        flags_n.rd = 1'b0;
        flags_n.wr = 1'b0;
      end
      if (flash_commit) begin
        flags_n.rd = 1'b0;
        flags_n.wr = 1'b0;
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        flags_q <= '0;
        tag_q   <= '0;
      end else begin
        flags_q <= flags_n;
        tag_q   <= tag_n;
      end
    end

    assign valid_v[i] = flags_q.valid;
    assign dirty_v[i] = flags_q.dirty;
    assign rd_v[i]    = flags_q.rd;
    assign wr_v[i]    = flags_q.wr;
    assign tag_v[i]   = tag_q;
  end

  // R6: a flash clear leaves no speculative mark anywhere
  a_r6_flash_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (flash_abort || flash_commit) |=> (rd_v == '0 && wr_v == '0));
endmodule

// File: rtl/tx_wb_ctrl.sv
module tx_wb_ctrl #(
  parameter int ADDR_W = 12,
  parameter int NBLK   = 8,
  localparam int IDX_W = $clog2(NBLK),
  localparam int TAG_W = ADDR_W - IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_wb_addr,
  input  logic [IDX_W-1:0]  start_idx,
  input  logic [TAG_W-1:0]  start_tag,
  input  logic              start_hit,
  input  logic              start_write,
  input  logic              start_tx,
  input  logic              abort_now,
  input  logic              commit_now,
  input  logic              wb_ready,
  output logic              busy,
  output logic              wb_valid,
  output logic [ADDR_W-1:0] wb_addr,
  output logic              done,
  output logic [IDX_W-1:0]  p_idx,
  output logic [TAG_W-1:0]  p_tag,
  output logic              p_hit,
  output logic              p_write,
  output logic              p_tx,
  output logic              p_kill
);
  typedef enum logic {WB_IDLE, WB_WAIT} wb_state_e;
  wb_state_e state_q;

  assign busy     = (state_q == WB_WAIT);
  assign wb_valid = busy;
  assign done     = busy && wb_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= WB_IDLE;
      wb_addr <= '0;
      p_idx   <= '0;
      p_tag   <= '0;
      p_hit   <= 1'b0;
      p_write <= 1'b0;
      p_tx    <= 1'b0;
      p_kill  <= 1'b0;
    end else if (start) begin
      state_q <= WB_WAIT;
      wb_addr <= start_wb_addr;
      p_idx   <= start_idx;
      p_tag   <= start_tag;
      p_hit   <= start_hit;
      p_write <= start_write;
      p_tx    <= start_tx;
      p_kill  <= 1'b0;
    end else if (done) begin
      state_q <= WB_IDLE;
    end else if (busy) begin
      if (commit_now) p_tx <= 1'b0;
      if (abort_now && p_tx) p_kill <= 1'b1;
    end
  end

  // R11: request held with a stable address until accepted
  a_r11_wb_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid && !wb_ready) |=> (wb_valid && $stable(wb_addr)));
  // R11: a new writeback is never started over a pending one
  a_r11_single_pending: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !wb_valid);
endmodule

// File: rtl/tx_set_tracker.sv
module tx_set_tracker
  import tx_trk_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int NBLK   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_begin_i,
  input  logic              tx_end_i,
  input  logic              tx_abort_i,
  input  logic              acc_valid_i,
  output logic              acc_ready_o,
  input  logic              acc_write_i,
  input  logic [ADDR_W-1:0] acc_addr_i,
  input  logic              snp_valid_i,
  input  logic [ADDR_W-1:0] snp_addr_i,
  output logic              wb_valid_o,
  input  logic              wb_ready_i,
  output logic [ADDR_W-1:0] wb_addr_o,
  output logic              abort_o,
  output logic [1:0]        abort_cause_o,
  output logic [NBLK-1:0]   inv_mask_o,
  output logic              commit_o,
  output logic              tx_active_o
);
  localparam int IDX_W = $clog2(NBLK);
  localparam int TAG_W = ADDR_W - IDX_W;

  logic [NBLK-1:0]            v_v, d_v, r_v, w_v;
  logic [NBLK-1:0][TAG_W-1:0] tag_v;
  logic [IDX_W-1:0]           a_idx, s_idx, p_idx;
  logic [TAG_W-1:0]           a_tag, s_tag, p_tag;
  logic                       a_hit, s_hit;
  logic                       p_hit, p_write, p_tx, p_kill;
  logic                       wb_busy, wb_done;
  logic                       active_q;

  tx_lookup #(.ADDR_W(ADDR_W), .NBLK(NBLK)) u_acc_lk (
    .addr(acc_addr_i), .valid_v(v_v), .tag_v(tag_v),
    .idx(a_idx), .tag(a_tag), .hit(a_hit));

  tx_lookup #(.ADDR_W(ADDR_W), .NBLK(NBLK)) u_snp_lk (
    .addr(snp_addr_i), .valid_v(v_v), .tag_v(tag_v),
    .idx(s_idx), .tag(s_tag), .hit(s_hit));

  // access classification
  logic acc_fire, vic_busy, vic_dirty, clean_hit, ovf, need_wb, conf, cmd;
  logic abort_now, commit_now, apply_now, apply_pend;
  abort_cause_e cause;

  assign acc_ready_o = !wb_busy;
  assign acc_fire    = acc_valid_i && acc_ready_o;
  assign vic_busy    = v_v[a_idx] && !a_hit && (r_v[a_idx] || w_v[a_idx]);
  assign vic_dirty   = v_v[a_idx] && !a_hit && d_v[a_idx];
  assign clean_hit   = a_hit && acc_write_i && active_q && d_v[a_idx] && !w_v[a_idx];
  assign ovf         = acc_fire && active_q && vic_busy;
  assign need_wb     = acc_fire && ((vic_dirty && !vic_busy) || clean_hit);
  assign conf        = snp_valid_i && active_q && s_hit && (r_v[s_idx] || w_v[s_idx]);
  assign cmd         = tx_abort_i && active_q;

  always_comb begin
    if (conf)      cause = CAUSE_CONFLICT;
    else if (ovf)  cause = CAUSE_OVERFLOW;
    else if (cmd)  cause = CAUSE_CMD;
    else           cause = CAUSE_NONE;
  end

  assign abort_now  = (cause != CAUSE_NONE);
  assign commit_now = tx_end_i && active_q && !abort_now;
  assign apply_now  = acc_fire && !need_wb && !abort_now;
  assign apply_pend = wb_done && !p_kill && !(abort_now && p_tx);

  tx_wb_ctrl #(.ADDR_W(ADDR_W), .NBLK(NBLK)) u_wb (
    .clk(clk), .rst_n(rst_n),
    .start(need_wb && !abort_now),
    .start_wb_addr(a_hit ? acc_addr_i : {tag_v[a_idx], a_idx}),
    .start_idx(a_idx), .start_tag(a_tag), .start_hit(a_hit),
    .start_write(acc_write_i), .start_tx(active_q),
    .abort_now(abort_now), .commit_now(commit_now),
    .wb_ready(wb_ready_i),
    .busy(wb_busy), .wb_valid(wb_valid_o), .wb_addr(wb_addr_o), .done(wb_done),
    .p_idx(p_idx), .p_tag(p_tag), .p_hit(p_hit), .p_write(p_write),
    .p_tx(p_tx), .p_kill(p_kill));

  function automatic blk_flags_t next_flags(input logic hit, input logic wr,
                                            input logic tx, input blk_flags_t cur);
    blk_flags_t f;
    f.valid = 1'b1;
    if (hit) begin
      f.dirty = cur.dirty | wr;
      f.rd    = cur.rd | (tx & ~wr);
      f.wr    = cur.wr | (tx & wr);
    end else begin
      f.dirty = wr;
      f.rd    = tx & ~wr;
      f.wr    = tx & wr;
    end
    return f;
  endfunction

  logic             upd_en;
  logic [IDX_W-1:0] upd_idx;
  logic [TAG_W-1:0] upd_tag;
  blk_flags_t       upd_flags, p_cur, a_cur;

  assign p_cur = '{valid: v_v[p_idx], dirty: 1'b0, rd: r_v[p_idx], wr: w_v[p_idx]};
  assign a_cur = '{valid: v_v[a_idx], dirty: d_v[a_idx], rd: r_v[a_idx], wr: w_v[a_idx]};

  always_comb begin
    upd_en    = 1'b0;
    upd_idx   = a_idx;
    upd_tag   = a_tag;
    upd_flags = '0;
    if (apply_pend) begin
      upd_en    = 1'b1;
      upd_idx   = p_idx;
      upd_tag   = p_tag;
      upd_flags = next_flags(p_hit, p_write, p_tx, p_cur);
    end else if (apply_now) begin
      upd_en    = 1'b1;
      upd_flags = next_flags(a_hit, acc_write_i, active_q, a_cur);
    end
  end

  tx_tag_store #(.ADDR_W(ADDR_W), .NBLK(NBLK)) u_store (
    .clk(clk), .rst_n(rst_n),
    .upd_en(upd_en), .upd_idx(upd_idx), .upd_tag(upd_tag), .upd_flags(upd_flags),
    .clean_en(wb_done), .clean_idx(p_idx),
    .flash_abort(abort_now), .flash_commit(commit_now),
    .valid_v(v_v), .dirty_v(d_v), .rd_v(r_v), .wr_v(w_v), .tag_v(tag_v));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q      <= 1'b0;
      abort_o       <= 1'b0;
      abort_cause_o <= 2'd0;
      inv_mask_o    <= '0;
      commit_o      <= 1'b0;
    end else begin
      active_q      <= active_q ? !(abort_now || commit_now) : tx_begin_i;
      abort_o       <= abort_now;
      abort_cause_o <= cause;
      inv_mask_o    <= abort_now ? w_v : '0;
      commit_o      <= commit_now;
    end
  end

  assign tx_active_o = active_q;

  // R10: one outcome per transaction end
  a_r10_single_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    !(abort_o && commit_o));
  // R8: nothing ends when nothing is running
  a_r8_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_active_o |=> (!abort_o && !commit_o));
  // R4: discards are reported only with an abort
  a_r4_inv_with_abort: assert property (@(posedge clk) disable iff (!rst_n)
    (|inv_mask_o) |-> abort_o);
  // R11: access port stalls while a writeback waits
  a_r11_ready_low: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid_o |-> !acc_ready_o);
  // R13: a cause accompanies every abort and only an abort
  a_r13_cause_tag: assert property (@(posedge clk) disable iff (!rst_n)
    abort_o == (abort_cause_o != 2'd0));
  // R9: overflow follows an access cycle
  a_r9_overflow_from_access: assert property (@(posedge clk) disable iff (!rst_n)
    (abort_o && abort_cause_o == 2'd3) |-> $past(acc_valid_i));
endmodule

// File: tb/tx_set_tracker_tb.sv
`timescale 1ns/1ps
module tx_set_tracker_tb;
  localparam int AW = 12;
  localparam int NB = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_begin = 0, tx_end = 0, tx_abort = 0;
  logic acc_valid = 0, acc_write = 0;
  logic [AW-1:0] acc_addr = '0;
  logic snp_valid = 0;
  logic [AW-1:0] snp_addr = '0;
  logic wb_ready = 1'b1;
  logic acc_ready, wb_valid, abort_o, commit_o, tx_active;
  logic [AW-1:0] wb_addr;
  logic [1:0] cause_o;
  logic [NB-1:0] inv_mask;

  always #2.5 clk = ~clk;

  tx_set_tracker #(.ADDR_W(AW), .NBLK(NB)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .tx_begin_i(tx_begin), .tx_end_i(tx_end), .tx_abort_i(tx_abort),
    .acc_valid_i(acc_valid), .acc_ready_o(acc_ready), .acc_write_i(acc_write),
    .acc_addr_i(acc_addr), .snp_valid_i(snp_valid), .snp_addr_i(snp_addr),
    .wb_valid_o(wb_valid), .wb_ready_i(wb_ready), .wb_addr_o(wb_addr),
    .abort_o(abort_o), .abort_cause_o(cause_o), .inv_mask_o(inv_mask),
    .commit_o(commit_o), .tx_active_o(tx_active));

  int n_checks = 0, n_fail = 0;

  // ---------------- behavioural reference ----------------
  bit mv[NB], md[NB], mr[NB], mw[NB];
  int mtag[NB];
  bit mact, m_busy, ph, pw, ptx, pk;
  int pi, pt, pwa;
  bit mo_abort, mo_commit;
  int mo_cause, mo_inv;
  int ai, at, si, st, cz, inv;
  bit f_acc, was_busy, ahit, shit, vbusy, vdirty, ovf, nwb, conf, cmd, ab, cm;

  task automatic mapply(int i, int t, bit h, bit w, bit tx);
    if (h) begin
      mv[i] = 1; md[i] = md[i] | w;
      mr[i] = mr[i] | (tx & !w); mw[i] = mw[i] | (tx & w);
    end else begin
      mv[i] = 1; mtag[i] = t; md[i] = w; mr[i] = tx & !w; mw[i] = tx & w;
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NB; i++) begin mv[i]=0; md[i]=0; mr[i]=0; mw[i]=0; mtag[i]=0; end
      mact = 0; m_busy = 0; pwa = 0; pk = 0; ptx = 0;
      mo_abort = 0; mo_commit = 0; mo_cause = 0; mo_inv = 0;
    end else begin
      was_busy = m_busy;
      f_acc = acc_valid && !m_busy;
      ai = int'(acc_addr) % NB; at = int'(acc_addr) / NB;
      si = int'(snp_addr) % NB; st = int'(snp_addr) / NB;
      ahit = mv[ai] && mtag[ai] == at;
      shit = mv[si] && mtag[si] == st;
      vbusy = mv[ai] && !ahit && (mr[ai] || mw[ai]);
      vdirty = mv[ai] && !ahit && md[ai];
      ovf = f_acc && mact && vbusy;
      nwb = f_acc && ((vdirty && !vbusy) || (ahit && acc_write && mact && md[ai] && !mw[ai]));
      conf = snp_valid && mact && shit && (mr[si] || mw[si]);
      cmd = tx_abort && mact;
      cz = conf ? 2 : ovf ? 3 : cmd ? 1 : 0;
      ab = (cz != 0);
      cm = tx_end && mact && !ab;
      inv = 0;
      for (int i = 0; i < NB; i++) if (mw[i]) inv |= (1 << i);
      if (was_busy && wb_ready) begin
        md[pi] = 0;
        if (!(pk || (ab && ptx))) mapply(pi, pt, ph, pw, ptx);
        m_busy = 0;
      end else if (was_busy) begin
        if (cm) ptx = 0;
        if (ab && ptx) pk = 1;
      end
      if (f_acc && !ab) begin
        if (nwb) begin
          m_busy = 1; pi = ai; pt = at; ph = ahit; pw = acc_write; ptx = mact; pk = 0;
          pwa = ahit ? int'(acc_addr) : mtag[ai] * NB + ai;
        end else mapply(ai, at, ahit, acc_write, mact);
      end
      if (ab) for (int i = 0; i < NB; i++) begin
        if (mw[i]) begin mv[i] = 0; md[i] = 0; end
        mr[i] = 0; mw[i] = 0;
      end
      if (cm) for (int i = 0; i < NB; i++) begin mr[i] = 0; mw[i] = 0; end
      mact = mact ? !(ab || cm) : tx_begin;
      mo_abort = ab; mo_cause = cz; mo_inv = ab ? inv : 0; mo_commit = cm;
    end
  end

  // ---------------- checking helpers ----------------
  task automatic chk(string req, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cmp_model();
    chk("R11 acc_ready vs model", int'(acc_ready), int'(!m_busy));
    chk("R11 wb_valid vs model", int'(wb_valid), int'(m_busy));
    if (m_busy) chk("R12 wb_addr vs model", int'(wb_addr), pwa);
    chk("R1 abort vs model", int'(abort_o), int'(mo_abort));
    chk("R10 cause vs model", int'(cause_o), mo_cause);
    chk("R4 inv_mask vs model", int'(inv_mask), mo_inv);
    chk("R5 commit vs model", int'(commit_o), int'(mo_commit));
    chk("R13 active vs model", int'(tx_active), int'(mact));
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    if (rst_n) cmp_model();
  endtask

  function automatic logic [AW-1:0] mk(int t, int i);
    return AW'(t * NB + i);
  endfunction

  task automatic pulse_begin(); tx_begin = 1; tick(); tx_begin = 0; endtask
  task automatic pulse_end();   tx_end = 1;   tick(); tx_end = 0;   endtask
  task automatic pulse_abort(); tx_abort = 1; tick(); tx_abort = 0; endtask
  task automatic snoop(logic [AW-1:0] a);
    snp_valid = 1; snp_addr = a; tick(); snp_valid = 0;
  endtask
  task automatic access(bit w, logic [AW-1:0] a);
    bit seen;
    acc_valid = 1; acc_write = w; acc_addr = a;
    do begin seen = acc_ready; tick(); end while (!seen);
    acc_valid = 0;
  endtask

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R13 reset state
    chk("R13 reset acc_ready", int'(acc_ready), 1);
    chk("R13 reset active", int'(tx_active), 0);
    chk("R13 reset abort", int'(abort_o), 0);
    chk("R13 reset wb_valid", int'(wb_valid), 0);

    // R8: idle snoop and stray end/abort
    snoop(mk(1, 0));
    chk("R8 idle snoop no abort", int'(abort_o), 0);
    pulse_end();
    chk("R8 stray end no commit", int'(commit_o), 0);
    pulse_abort();
    chk("R8 stray abort ignored", int'(abort_o), 0);

    // R7: non-transactional store leaves no mark (block idx0 now dirty)
    access(1, mk(1, 0));
    pulse_begin();
    chk("R13 begin sets active", int'(tx_active), 1);
    snoop(mk(1, 0));
    chk("R7 no mark from plain access", int'(abort_o), 0);
    pulse_end();
    chk("R5 commit pulse", int'(commit_o), 1);

    // R1: transactional load then remote write
    pulse_begin();
    access(0, mk(1, 0));
    snoop(mk(1, 0));
    chk("R1 conflict abort", int'(abort_o), 1);
    chk("R1 conflict cause", int'(cause_o), 2);
    chk("R1 active drops", int'(tx_active), 0);
    // R4 + R12: read-only block kept valid and dirty
    access(0, mk(2, 0));
    chk("R12 victim writeback", int'(wb_valid), 1);
    chk("R12 victim address", int'(wb_addr), int'(mk(1, 0)));
    tick();
    chk("R11 released after ready", int'(wb_valid), 0);

    // R2: transactional store then remote write
    pulse_begin();
    access(1, mk(1, 1));
    snoop(mk(1, 1));
    chk("R2 abort", int'(abort_o), 1);
    chk("R2 inv_mask", int'(inv_mask), 2);
    access(1, mk(2, 1));
    chk("R4 discarded block not written back", int'(wb_valid), 0);

    // R3: transactional store to a dirty block cleans it first
    pulse_begin();
    access(1, mk(2, 1));
    chk("R3 clean writeback", int'(wb_valid), 1);
    chk("R3 clean address", int'(wb_addr), int'(mk(2, 1)));
    tick();
    snoop(mk(2, 1));
    chk("R3 store applied after clean", int'(abort_o), 1);
    chk("R3 inv_mask", int'(inv_mask), 2);

    // R5: committed data stays valid and dirty
    pulse_begin();
    access(1, mk(4, 2));
    pulse_end();
    chk("R5 commit", int'(commit_o), 1);
    access(0, mk(5, 2));
    chk("R5 committed block evicted with writeback", int'(wb_valid), 1);
    chk("R5 writeback address", int'(wb_addr), int'(mk(4, 2)));
    tick();

    // R6: marks cleared by commit
    pulse_begin();
    access(0, mk(1, 3));
    pulse_end();
    pulse_begin();
    snoop(mk(1, 3));
    chk("R6 stale mark cleared", int'(abort_o), 0);
    // R13: command abort
    pulse_abort();
    chk("R13 command abort", int'(abort_o), 1);
    chk("R13 command cause", int'(cause_o), 1);

    // R13: begin while active ignored
    pulse_begin();
    pulse_begin();
    pulse_end();
    chk("R13 nested begin ignored", int'(commit_o), 1);
    chk("R13 inactive after single end", int'(tx_active), 0);

    // R9: overflow
    pulse_begin();
    access(0, mk(1, 4));
    access(0, mk(2, 4));
    chk("R9 overflow abort", int'(abort_o), 1);
    chk("R9 overflow cause", int'(cause_o), 3);

    // R10: abort beats commit
    pulse_begin();
    access(0, mk(1, 5));
    tx_end = 1; snp_valid = 1; snp_addr = mk(1, 5);
    tick();
    tx_end = 0; snp_valid = 0;
    chk("R10 abort wins", int'(abort_o), 1);
    chk("R10 no commit", int'(commit_o), 0);
    // R10: cause priority conflict over overflow and command
    pulse_begin();
    access(0, mk(1, 6));
    acc_valid = 1; acc_write = 0; acc_addr = mk(2, 6);
    snp_valid = 1; snp_addr = mk(1, 6); tx_abort = 1;
    tick();
    acc_valid = 0; snp_valid = 0; tx_abort = 0;
    chk("R10 cause priority", int'(cause_o), 2);

    // R11: back-pressure on writeback
    wb_ready = 0;
    access(1, mk(1, 7));
    access(0, mk(2, 7));
    for (int k = 0; k < 3; k++) begin
      chk("R11 held valid", int'(wb_valid), 1);
      chk("R11 held address", int'(wb_addr), int'(mk(1, 7)));
      chk("R11 access stalled", int'(acc_ready), 0);
      tick();
    end
    wb_ready = 1;
    tick();
    chk("R11 released", int'(wb_valid), 0);
    chk("R11 ready again", int'(acc_ready), 1);

    // mixed traffic against the model
    for (int c = 0; c < 3000; c++) begin
      acc_valid = ($urandom % 3) == 0;
      acc_write = $urandom % 2;
      acc_addr  = mk($urandom % 3, $urandom % NB);
      snp_valid = ($urandom % 6) == 0;
      snp_addr  = mk($urandom % 3, $urandom % NB);
      tx_begin  = ($urandom % 8) == 0;
      tx_end    = ($urandom % 16) == 0;
      tx_abort  = ($urandom % 32) == 0;
      wb_ready  = $urandom % 2;
      tick();
    end
    acc_valid = 0; snp_valid = 0; tx_begin = 0; tx_end = 0; tx_abort = 0; wb_ready = 1;
    tick();

    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule